// File: doc/BRIEF.md
# Interrupt enable delay controller

This block holds the processor's master interrupt-enable flag and applies the one-instruction lag that follows an enable request. The instruction decoder drives a strobe at the start of every instruction and one-cycle pulses when it executes an enable-interrupts, disable-interrupts or return-from-interrupt instruction. The interrupt dispatcher drives a pulse when it accepts an interrupt. The block answers with the current enable flag, which gates dispatch, and a pending indication that stays high while an enable request is still counting down.

An enable request loads a small countdown instead of setting the flag. Each instruction start takes one off a nonzero count, and the start that brings the count to zero also sets the flag. So the instruction after the enable runs with interrupts still masked, and they open at the start of the instruction after that. A disable drops both the flag and any count in progress. A return-from-interrupt opens the flag at once, with no count. An accepted interrupt closes the flag so that its handler is not entered a second time.

Top module: `irq_enable_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `int_en` and `en_pending` are both 0.
- R2: An enable pulse (`ei_req`) with no disable pulse in the same cycle loads the count with LOAD_VAL (default 2) in the next cycle. `en_pending` is then 1. The pulse does not set `int_en` by itself.
- R3: The count changes only on an `instr_start` cycle, or on a cycle with an enable or disable pulse. On an `instr_start` cycle with no enable or disable pulse, a nonzero count drops by one and a zero count stays at zero.
- R4: An `instr_start` cycle that finds the count at 1 sets `int_en` from the next cycle on. With the default LOAD_VAL the flag therefore rises after the second instruction start that follows the enable, unless R5 or R7 applies.
- R5: A disable pulse (`di_req`) clears both `int_en` and the count in the next cycle. It wins over an enable, a return-from-interrupt, an acknowledge and an expiring count in the same cycle.
- R6: A return-from-interrupt pulse (`reti_req`) sets `int_en` in the next cycle whatever the count holds, and it leaves the count unchanged.
- R7: A dispatch acknowledge (`irq_ack`) clears `int_en` in the next cycle. It wins over a return-from-interrupt or an expiring count in the same cycle, and it does not change the count.
- R8: An enable pulse that arrives while a count is already running reloads the count to LOAD_VAL. This includes the cycle in which an `instr_start` would have decremented the count.
- R9: `en_pending` is 1 exactly when the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_start | input | 1 | One-cycle strobe at the start of each instruction |
| ei_req | input | 1 | Enable-interrupts instruction executed |
| di_req | input | 1 | Disable-interrupts instruction executed |
| reti_req | input | 1 | Return-from-interrupt instruction executed |
| irq_ack | input | 1 | Interrupt accepted by the dispatcher |
| int_en | output | 1 | Master interrupt-enable flag |
| en_pending | output | 1 | An enable request is still counting down |

## Verification
The hardest cases to reach are the collisions: an enable that reloads a count in the same cycle that an instruction start would have expired it, and a disable or acknowledge that lands on the very cycle the count reaches zero. Directed sequences first wind the count down to 1 with a known number of instruction starts. They then fire the colliding pulses together on the next start, and after that the flag and the pending output are observed. A long run of sparse random pulses, checked against a behavioural model on every clock, then covers the mixed orderings.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // Action applied to the countdown register this cycle
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_ZERO = 2'd3
  } cnt_op_e;

  // Action applied to the enable flag this cycle
  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_SET  = 2'd1,
    FLG_CLR  = 2'd2
  } flg_op_e;

endpackage

// File: rtl/irq_gate_arbiter.sv
module irq_gate_arbiter
  import irq_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    instr_start,
  input  logic    ei_req,
  input  logic    di_req,
  input  logic    reti_req,
  input  logic    irq_ack,
  input  logic    cnt_nz,
  input  logic    expire,
  output cnt_op_e cnt_op,
  output flg_op_e flg_op
);

  // Countdown priority: disable > enable (re)load > decrement > hold
  always_comb begin
    if (di_req)                     cnt_op = CNT_ZERO;
    else if (ei_req)                cnt_op = CNT_LOAD;
    else if (instr_start && cnt_nz) cnt_op = CNT_DEC;
    else                            cnt_op = CNT_HOLD;
  end

  // Flag priority: disable > acknowledge > (return | expiry) > hold
  always_comb begin
    if (di_req || irq_ack)          flg_op = FLG_CLR;
    else if (reti_req || expire)    flg_op = FLG_SET;
    else                            flg_op = FLG_HOLD;
  end

  AST_DI_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    di_req |-> (cnt_op == CNT_ZERO && flg_op == FLG_CLR)); // R5
  AST_ACK_NOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (flg_op != FLG_SET && cnt_op != CNT_LOAD || ei_req)); // R7

endmodule

// File: rtl/irq_gate_countdown.sv
module irq_gate_countdown
  import irq_gate_pkg::*;
#(
  parameter int LOAD_VAL = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    instr_start,
  input  cnt_op_e cnt_op,
  output logic    cnt_nz,
  output logic    expire
);

  localparam int CNT_W = $clog2(LOAD_VAL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    unique case (cnt_op)
      CNT_ZERO: cnt_d = '0;
      CNT_LOAD: cnt_d = CNT_W'(LOAD_VAL);
      CNT_DEC:  cnt_d = cnt_q - CNT_W'(1);
      default:  cnt_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_nz = (cnt_q != '0);
  assign expire = instr_start && (cnt_q == CNT_W'(1));

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_op == CNT_LOAD) |=> (cnt_q == CNT_W'(LOAD_VAL))); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LOAD_VAL)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_op == CNT_HOLD) |=> $stable(cnt_q)); // R3
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_op == CNT_DEC) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3

endmodule

// File: rtl/irq_gate_flag.sv
module irq_gate_flag
  import irq_gate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  flg_op_e flg_op,
  output logic    flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = (flg_op != FLG_HOLD);
    flag_d  = (flg_op == FLG_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_op == FLG_HOLD) |=> $stable(flag_q)); // R2

endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate
  import irq_gate_pkg::*;
#(
  parameter int LOAD_VAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_start,
  input  logic ei_req,
  input  logic di_req,
  input  logic reti_req,
  input  logic irq_ack,
  output logic int_en,
  output logic en_pending
);

  cnt_op_e cnt_op;
  flg_op_e flg_op;
  logic    cnt_nz;
  logic    expire;

  irq_gate_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .ei_req      (ei_req),
    .di_req      (di_req),
    .reti_req    (reti_req),
    .irq_ack     (irq_ack),
    .cnt_nz      (cnt_nz),
    .expire      (expire),
    .cnt_op      (cnt_op),
    .flg_op      (flg_op)
  );

  irq_gate_countdown #(.LOAD_VAL(LOAD_VAL)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .cnt_op      (cnt_op),
    .cnt_nz      (cnt_nz),
    .expire      (expire)
  );

  irq_gate_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .flg_op (flg_op),
    .flag   (int_en)
  );

  assign en_pending = cnt_nz;

  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    di_req |=> (!int_en && !en_pending)); // R5
  AST_RETI_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_req && !di_req && !irq_ack) |=> int_en); // R6
  AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !int_en); // R7
  AST_EI_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_req && !di_req) |=> en_pending); // R2
  AST_EXPIRY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !di_req && !irq_ack) |=> int_en); // R4
  AST_NO_SPONTANEOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> $past(reti_req || expire)); // R4

endmodule

// File: tb/test_irq_enable_gate.sv
module test_irq_enable_gate;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_start = 1'b0;
  logic ei_req = 1'b0;
  logic di_req = 1'b0;
  logic reti_req = 1'b0;
  logic irq_ack = 1'b0;
  logic int_en;
  logic en_pending;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  bit m_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_enable_gate i_irq_enable_gate (
    .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .ei_req(ei_req),
    .di_req(di_req), .reti_req(reti_req), .irq_ack(irq_ack),
    .int_en(int_en), .en_pending(en_pending)
  );

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; model updated at the edge, outputs compared after it
  task automatic step(input bit st, input bit ei, input bit di, input bit rt,
                      input bit ak, input string tag);
    bit expire;
    @(negedge clk);
    instr_start = st; ei_req = ei; di_req = di; reti_req = rt; irq_ack = ak;
    @(posedge clk);
    expire = st && (m_cnt == 1);
    if (di)                   m_cnt = 0;
    else if (ei)              m_cnt = 2;
    else if (st && m_cnt > 0) m_cnt = m_cnt - 1;
    if (di || ak)             m_en = 1'b0;
    else if (rt || expire)    m_en = 1'b1;
    #1;
    check(tag, int_en, m_en, "int_en");
    check(tag, en_pending, (m_cnt != 0), "en_pending");
    instr_start = 0; ei_req = 0; di_req = 0; reti_req = 0; irq_ack = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int_en, 1'b0, "int_en in reset");
    check("R1", en_pending, 1'b0, "en_pending in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1");

    // Basic lag: EI, then two instruction starts, idle cycles between
    step(1, 1, 0, 0, 0, "R2");
    check("R2", int_en, 1'b0, "EI alone leaves flag");
    step(0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    check("R9", en_pending, 1'b1, "pending at count 1");
    step(0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R4");
    check("R4", int_en, 1'b1, "flag after second start");
    step(1, 0, 0, 0, 0, "R3");
    check("R9", en_pending, 1'b0, "saturated at zero");

    // Disable cancels a pending enable
    step(1, 0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, 0, "R2");
    step(1, 0, 1, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    check("R5", int_en, 1'b0, "cancelled enable stays closed");

    // Disable on the expiring start
    step(1, 1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, "R5");
    check("R5", int_en, 1'b0, "DI beats expiry");
    // Disable with EI and RETI together
    step(1, 1, 1, 1, 0, "R5");
    check("R5", en_pending, 1'b0, "DI beats EI");

    // RETI opens immediately, count untouched
    step(0, 1, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R6");
    check("R6", en_pending, 1'b1, "RETI keeps count");
    step(1, 0, 0, 0, 1, "R7");
    check("R7", int_en, 1'b0, "ACK closes");
    step(1, 0, 0, 0, 1, "R7");
    check("R7", int_en, 1'b0, "ACK beats expiry");
    step(0, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 1, 0, "R6");

    // Reload while pending, including on the expiring start
    step(1, 0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    check("R8", int_en, 1'b1, "expiry still opens on reload cycle");
    step(1, 0, 1, 0, 0, "R5");
    step(1, 1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    check("R8", int_en, 1'b1, "opens after reload counts out");

    // Random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, ($urandom % 6) == 0, ($urandom % 12) == 0,
           ($urandom % 12) == 0, ($urandom % 10) == 0, "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule